// File: doc/BRIEF.md
# Receive DMA Descriptor-Chain Channel

This block is the receive side of a network MAC's DMA. It drains received frames from a receive FIFO into memory buffers. A linked chain of descriptors in memory says where each buffer lives. Each FIFO word carries an end-of-frame marker. Memory is reached through a single-outstanding, word-wide request/response port, and that port can report a bus error on any response.

Software writes a first-descriptor pointer together with the run bit into the control register while the channel is idle. From then on the channel works on its own until the chain ends. For each descriptor it:

- fetches the descriptor,
- moves one frame into the descriptor's buffer,
- writes the frame's byte count and a done mark back into the descriptor,
- then either follows the link or stops.

Software has no way to halt it. While the run bit reads 1, the control register ignores all writes. Only the hardware clears the run bit, either after the last descriptor or on a bus error. A status register records errors and buffer overruns. Its bits are sticky and are cleared by writing 1.

Top module: `rxdma_chain`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0, and neither a memory request nor a FIFO pop is issued.
- R2: Writing the control register (select 0) with bit 0 = 1 while idle sets the run bit. The pointer is taken from bits [31:2]. The channel then reads four words in order from pointer+0, +4, +8 and +12. These are the buffer address, the buffer length in bytes, the link pointer, and a flags word whose bit 0 marks the end of the chain.
- R3: The k-th word of a frame is written to buffer address + 4k, in arrival order. The frame ends with the FIFO word whose end-of-frame marker is 1.
- R4: After each frame, the channel writes descriptor+12 with the bytes written (4 × words) in bits [31:16], 1 in bit 1 (done), and the end-of-chain flag in bit 0. All other bits are 0.
- R5: When the end-of-chain flag is 0, the channel fetches the descriptor at the link pointer right after the write-back. The run bit stays 1 throughout.
- R6: When the end-of-chain flag is 1, the channel issues no further request after the write-back, and the run bit returns to 0.
- R7: While the run bit is 1, a write to the control register changes neither the pointer nor the run bit, and it does not alter the channel's request sequence.
- R8: A bus error on a descriptor read ends processing with no further request. The run bit clears and status bit 0 (descriptor error) is set.
- R9: A bus error on a buffer write or on a write-back ends processing with no further request or FIFO pop. The run bit clears and status bit 1 (data error) is set.
- R10: FIFO words beyond the buffer capacity (length / 4 words) are popped and discarded without a memory write. In that case status bit 2 (overrun) is set and the chain continues.
- R11: Status bits (select 1) stay set until a write with a 1 in that bit position. A write with 0 there, or a restart of the channel, leaves them set.
- R12: A memory request holds its address, direction and write data unchanged until it is acknowledged, and only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronized on release |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| fifo_valid | input | 1 | Receive FIFO holds a word |
| fifo_data | input | 32 | Receive FIFO head word |
| fifo_last | input | 1 | Head word is the last one of its frame |
| fifo_pop | output | 1 | Consume the head word this cycle |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completed this cycle |
| mem_err | input | 1 | Bus error on the acknowledged request |

## Verification
The bench builds the channel with its default 32-bit addresses and 16-bit length field. It writes descriptors whose buffers hold only two to eight words, so a short frame can run past its buffer and reach the overrun path within a few cycles. A memory model with an acknowledge latency of 0 to 2 cycles, together with FIFO gaps, makes requests stay pending across several edges, which exercises the hold rule. Error injection at a chosen address and direction reaches the descriptor-error and data-error exits both in the middle of a chain and right after a restart.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESC,
    ST_RXWAIT,
    ST_DWRITE,
    ST_WBACK
  } rx_state_e;

  localparam int unsigned STAT_W    = 3;
  localparam int unsigned STAT_DERR = 0;
  localparam int unsigned STAT_WERR = 1;
  localparam int unsigned STAT_OVR  = 2;
endpackage

// File: rtl/rxdma_regs.sv
module rxdma_regs #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_wr,
  input  logic                            reg_sel,
  input  logic [31:0]                     reg_wdata,
  output logic [31:0]                     reg_rdata,
  output logic                            start,
  output logic [ADDR_W-1:0]               start_ptr,
  input  logic                            stop,
  input  logic [rxdma_pkg::STAT_W-1:0]    stat_set,
  output logic                            run,
  output logic [rxdma_pkg::STAT_W-1:0]    stat
);
  import rxdma_pkg::*;
  localparam int unsigned PW = ADDR_W - 2;

  logic [PW-1:0]     ptr_q, ptr_d;
  logic              run_q, run_d;
  logic [STAT_W-1:0] stat_q, stat_d;
  logic              ctrl_wr, ptr_en, stat_clr_en;
  logic [31:0]       ctrl_view;

  // control is accepted only while the channel is idle
  assign ctrl_wr     = reg_wr && !reg_sel;
  assign ptr_en      = ctrl_wr && !run_q;
  assign start       = ptr_en && reg_wdata[0];
  assign start_ptr   = {reg_wdata[ADDR_W-1:2], 2'b00};
  assign stat_clr_en = reg_wr && reg_sel;

  always_comb begin
    ptr_d = ptr_en ? reg_wdata[ADDR_W-1:2] : ptr_q;
    run_d = run_q;
    if (start)     run_d = 1'b1;
    else if (stop) run_d = 1'b0;
    stat_d = stat_q;
    if (stat_clr_en) stat_d = stat_d & ~reg_wdata[STAT_W-1:0];
    stat_d = stat_d | stat_set;   // a new event wins over a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      run_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      run_q  <= run_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    ctrl_view              = '0;
    ctrl_view[ADDR_W-1:2]  = ptr_q;
    ctrl_view[0]           = run_q;
  end

  assign reg_rdata = reg_sel ? 32'(stat_q) : ctrl_view;
  assign run       = run_q;
  assign stat      = stat_q;

  // R7: a control write during a run leaves the pointer untouched
  a_r7_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && ctrl_wr) |=> $stable(ptr_q));

  // R11: a sticky bit survives any cycle without a matching clear
  a_r11_stat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[STAT_DERR] && !(stat_clr_en && reg_wdata[STAT_DERR])) |=> stat_q[STAT_DERR]);
endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [ADDR_W-1:0]            start_ptr,
  input  logic                         fifo_valid,
  input  logic [31:0]                  fifo_data,
  input  logic                         fifo_last,
  output logic                         fifo_pop,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [31:0]                  mem_wdata,
  input  logic [31:0]                  mem_rdata,
  input  logic                         mem_ack,
  input  logic                         mem_err,
  output logic                         stop,
  output logic [rxdma_pkg::STAT_W-1:0] stat_set,
  output logic                         busy
);
  import rxdma_pkg::*;
  // word capacity of a buffer; the byte count field is 16 bits wide
  localparam int unsigned WCNT_W = LEN_W - 2;

  rx_state_e         st_q, st_d;
  logic [1:0]        idx_q, idx_d;
  logic [ADDR_W-1:0] desc_q, desc_d, buf_q, buf_d, nxt_q, nxt_d;
  logic [WCNT_W-1:0] cap_q, cap_d, wcnt_q, wcnt_d;
  logic              eoc_q, eoc_d, last_q, last_d;
  logic [31:0]       dat_q, dat_d;
  logic [15:0]       wb_bytes;

  assign wb_bytes = 16'({wcnt_q, 2'b00});

  always_comb begin
    st_d = st_q;  idx_d = idx_q;  desc_d = desc_q;  buf_d = buf_q;
    nxt_d = nxt_q;  cap_d = cap_q;  wcnt_d = wcnt_q;  eoc_d = eoc_q;
    last_d = last_q;  dat_d = dat_q;
    fifo_pop = 1'b0;  mem_req = 1'b0;  mem_we = 1'b0;
    mem_addr = '0;  mem_wdata = '0;  stop = 1'b0;  stat_set = '0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        desc_d = start_ptr;
        idx_d  = '0;
        st_d   = ST_DESC;
      end
      ST_DESC: begin
        mem_req  = 1'b1;
        mem_addr = desc_q + ADDR_W'({idx_q, 2'b00});
        if (mem_ack) begin
          if (mem_err) begin
            stat_set[STAT_DERR] = 1'b1;
            stop = 1'b1;
            st_d = ST_IDLE;
          end else begin
            unique case (idx_q)
              2'd0: buf_d = mem_rdata[ADDR_W-1:0];
              2'd1: cap_d = mem_rdata[LEN_W-1:2];
              2'd2: nxt_d = mem_rdata[ADDR_W-1:0];
              2'd3: begin
                eoc_d  = mem_rdata[0];
                wcnt_d = '0;
                st_d   = ST_RXWAIT;
              end
            endcase
            idx_d = idx_q + 2'd1;
          end
        end
      end
      ST_RXWAIT: if (fifo_valid) begin
        fifo_pop = 1'b1;
        dat_d    = fifo_data;
        last_d   = fifo_last;
        if (wcnt_q < cap_q) begin
          st_d = ST_DWRITE;
        end else begin
          stat_set[STAT_OVR] = 1'b1;      // word dropped
          if (fifo_last) st_d = ST_WBACK;
        end
      end
      ST_DWRITE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = buf_q + ADDR_W'({wcnt_q, 2'b00});
        mem_wdata = dat_q;
        if (mem_ack) begin
          if (mem_err) begin
            stat_set[STAT_WERR] = 1'b1;
            stop = 1'b1;
            st_d = ST_IDLE;
          end else begin
            wcnt_d = wcnt_q + WCNT_W'(1);
            st_d   = last_q ? ST_WBACK : ST_RXWAIT;
          end
        end
      end
      ST_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_q + ADDR_W'(12);
        mem_wdata = {wb_bytes, 14'b0, 1'b1, eoc_q};
        if (mem_ack) begin
          if (mem_err) begin
            stat_set[STAT_WERR] = 1'b1;
            stop = 1'b1;
            st_d = ST_IDLE;
          end else if (eoc_q) begin
            stop = 1'b1;
            st_d = ST_IDLE;
          end else begin
            desc_d = nxt_q;
            idx_d  = '0;
            st_d   = ST_DESC;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  idx_q <= '0;  desc_q <= '0;  buf_q <= '0;
      nxt_q <= '0;  cap_q <= '0;  wcnt_q <= '0;  eoc_q <= 1'b0;
      last_q <= 1'b0;  dat_q <= '0;
    end else begin
      st_q <= st_d;  idx_q <= idx_d;  desc_q <= desc_d;  buf_q <= buf_d;
      nxt_q <= nxt_d;  cap_q <= cap_d;  wcnt_q <= wcnt_d;  eoc_q <= eoc_d;
      last_q <= last_d;  dat_q <= dat_d;
    end
  end

  assign busy = (st_q != ST_IDLE);

  // R12: a pending request is held unchanged until acknowledged
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  // R3, R10: no buffer write ever lands past the buffer capacity
  a_r10_write_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && st_q == ST_DWRITE) |-> (wcnt_q < cap_q));
endmodule

// File: rtl/rxdma_chain.sv
module rxdma_chain #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              fifo_valid,
  input  logic [31:0]       fifo_data,
  input  logic              fifo_last,
  output logic              fifo_pop,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err
);
  import rxdma_pkg::*;

  logic              start, stop, run, busy;
  logic [ADDR_W-1:0] start_ptr;
  logic [STAT_W-1:0] stat_set, stat;

  rxdma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start(start),
    .start_ptr(start_ptr), .stop(stop), .stat_set(stat_set),
    .run(run), .stat(stat)
  );

  rxdma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_last(fifo_last),
    .fifo_pop(fifo_pop), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .stop(stop),
    .stat_set(stat_set), .busy(busy)
  );

  // R5, R6: the visible run bit tracks the engine being away from idle
  a_r5_run_matches_busy: assert property (@(posedge clk) disable iff (!rst_n)
    run == busy);

  // R8: a failed descriptor read turns the channel off and flags it
  a_r8_desc_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack && mem_err) |=> (!run && stat[STAT_DERR]));

  // R9: a failed write turns the channel off and flags it
  a_r9_data_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack && mem_err) |=> (!run && stat[STAT_WERR] && !mem_req));
endmodule

// File: tb/test_rxdma_chain.sv
module test_rxdma_chain;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        fifo_valid = 1'b0, fifo_last = 1'b0, fifo_pop;
  logic [31:0] fifo_data = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  int checks = 0, fails = 0, cyc = 0, lat = 0, seq = 0;
  logic [31:0] mem [1024];
  logic [31:0] fq_data[$];
  bit          fq_last[$];
  logic [31:0] ex_addr[$], ex_data[$];
  bit          ex_we[$];
  string       ex_tag[$];
  bit          err_on = 0, err_we = 0;
  logic [31:0] err_addr = '0;
  bit          pop_q = 0, pend = 0;
  logic [31:0] paddr = '0;

  rxdma_chain i_rxdma_chain (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_valid(fifo_valid),
    .fifo_data(fifo_data), .fifo_last(fifo_last), .fifo_pop(fifo_pop),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    pop_q <= fifo_pop;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  // memory responder, FIFO driver and R12 hold check
  always @(negedge clk) begin
    if (pend) begin
      checks++;
      if (!(mem_req && mem_addr == paddr)) begin
        fails++;
        $display("FAIL R12 held request: actual %h expected %h", mem_addr, paddr);
      end
    end
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req) begin
      if (lat > 0) lat--;
      else begin
        if (ex_addr.size() == 0) begin
          checks++; fails++;
          $display("FAIL R6/R8/R9 unexpected request: actual %h expected %h", mem_addr, 32'hffffffff);
        end else begin
          logic [31:0] ea, ed; bit ew; string tg;
          ea = ex_addr.pop_front(); ed = ex_data.pop_front();
          ew = ex_we.pop_front();   tg = ex_tag.pop_front();
          chk(mem_addr == ea, tg, "address", mem_addr, ea);
          chk(mem_we == ew, tg, "direction", 32'(mem_we), 32'(ew));
          if (ew) chk(mem_wdata == ed, tg, "write data", mem_wdata, ed);
        end
        mem_err = err_on && (mem_addr == err_addr) && (mem_we == err_we);
        mem_ack = 1'b1;
        if (!mem_we) mem_rdata = mem[mem_addr[11:2]];
        else if (!mem_err) mem[mem_addr[11:2]] = mem_wdata;
        lat = seq % 3;
        seq++;
      end
    end
    pend  = mem_req && !mem_ack;
    paddr = mem_addr;
    if (pop_q && fq_data.size() > 0) begin
      void'(fq_data.pop_front());
      void'(fq_last.pop_front());
    end
    fifo_valid = (fq_data.size() > 0) && (cyc % 5 != 4);
    fifo_data  = (fq_data.size() > 0) ? fq_data[0] : '0;
    fifo_last  = (fq_last.size() > 0) ? fq_last[0] : 1'b0;
  end

  task automatic reg_write(input bit sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input bit sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic set_desc(input int a, input int b, input int len, input int nx, input bit eoc);
    mem[a/4] = b; mem[a/4+1] = len; mem[a/4+2] = nx; mem[a/4+3] = {31'b0, eoc};
  endtask

  task automatic push_frame(input int base, input int n);
    for (int i = 0; i < n; i++) begin
      fq_data.push_back(32'(base + i));
      fq_last.push_back(i == n - 1);
    end
  endtask

  task automatic ex(input logic [31:0] a, input bit w, input logic [31:0] d, input string t);
    ex_addr.push_back(a); ex_we.push_back(w); ex_data.push_back(d); ex_tag.push_back(t);
  endtask

  function automatic bit hits(input logic [31:0] a, input bit w);
    return err_on && a == err_addr && w == err_we;
  endfunction

  // behavioural model of the chain walk: expected requests and status
  task automatic model(input int ptr, output logic [2:0] st);
    int d = ptr, fi = 0;
    st = '0;
    forever begin
      int b, cap, nx, k; bit eoc;
      for (int i = 0; i < 4; i++) begin
        ex(32'(d + 4*i), 1'b0, '0, (d == ptr) ? "R2" : "R5");
        if (hits(32'(d + 4*i), 1'b0)) begin st[0] = 1'b1; return; end
      end
      b = mem[d/4]; cap = mem[d/4+1] / 4; nx = mem[d/4+2]; eoc = mem[d/4+3][0];
      k = 0;
      forever begin
        bit lst = fq_last[fi];
        if (k < cap) begin
          ex(32'(b + 4*k), 1'b1, fq_data[fi], "R3");
          if (hits(32'(b + 4*k), 1'b1)) begin st[1] = 1'b1; return; end
          k++;
        end else st[2] = 1'b1;
        fi++;
        if (lst) break;
      end
      ex(32'(d + 12), 1'b1, {16'(4*k), 14'b0, 1'b1, eoc}, "R4");
      if (hits(32'(d + 12), 1'b1)) begin st[1] = 1'b1; return; end
      if (eoc) return;
      d = nx;
    end
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] c;
    int n = 0;
    do begin reg_read(1'b0, c); n++; end while (c[0] && n < 5000);
    chk(c[0] == 1'b0, req, "run bit cleared", c, {c[31:1], 1'b0});
    repeat (4) @(negedge clk);
    chk(ex_addr.size() == 0, req, "all expected requests seen", 32'(ex_addr.size()), 0);
    chk(!mem_req, req, "no request once idle", 32'(mem_req), 0);
  endtask

  task automatic run_chain(input int ptr, input string req, output logic [2:0] st);
    model(ptr, st);
    reg_write(1'b0, 32'(ptr) | 32'h1);
  endtask

  initial begin
    logic [31:0] r;
    logic [2:0]  st;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    reg_read(1'b0, r); chk(r == 0, "R1", "control at reset", r, 0);
    reg_read(1'b1, r); chk(r == 0, "R1", "status at reset", r, 0);
    chk(!mem_req && !fifo_pop, "R1", "quiet outputs", {30'b0, mem_req, fifo_pop}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // single descriptor, end of chain (R2 R3 R4 R6)
    set_desc(32'h100, 32'h400, 16, 0, 1'b1);
    push_frame(32'hA000, 3);
    run_chain(32'h100, "R6", st);
    wait_idle("R6");
    reg_read(1'b1, r); chk(r == 32'(st), "R6", "status after clean frame", r, 32'(st));
    chk(mem[32'h10c/4] == {16'd12, 14'b0, 2'b11}, "R4", "flags written back", mem[32'h10c/4], {16'd12, 14'b0, 2'b11});

    // three-descriptor chain with an overrun and locked control (R5 R7 R10)
    set_desc(32'h200, 32'h500, 16, 32'h210, 1'b0);
    set_desc(32'h210, 32'h600, 8,  32'h220, 1'b0);
    set_desc(32'h220, 32'h680, 32, 0,       1'b1);
    push_frame(32'hB000, 2); push_frame(32'hC000, 5); push_frame(32'hD000, 1);
    run_chain(32'h200, "R5", st);
    repeat (3) @(negedge clk);
    reg_read(1'b0, r); chk(r == 32'h201, "R5", "run bit set while chaining", r, 32'h201);
    reg_write(1'b0, 32'h301);   // R7 attempt with run
    reg_write(1'b0, 32'h300);   // R7 attempt to stop
    reg_read(1'b0, r); chk(r == 32'h201, "R7", "control locked while running", r, 32'h201);
    wait_idle("R5");
    reg_read(1'b0, r); chk(r == 32'h200, "R7", "pointer unchanged", r, 32'h200);
    reg_read(1'b1, r); chk(r == 32'h4 && st == 3'b100, "R10", "overrun status", r, 32'h4);
    chk(fq_data.size() == 0, "R10", "excess words drained", 32'(fq_data.size()), 0);
    chk(mem[32'h21c/4] == {16'd8, 14'b0, 2'b10}, "R10", "overrun byte count", mem[32'h21c/4], {16'd8, 14'b0, 2'b10});
    reg_write(1'b1, 32'h7);
    reg_read(1'b1, r); chk(r == 0, "R11", "write-1 clears status", r, 0);

    // descriptor read error mid-fetch (R8)
    set_desc(32'h300, 32'h700, 16, 0, 1'b1);
    err_on = 1; err_we = 0; err_addr = 32'h308;
    run_chain(32'h300, "R8", st);
    wait_idle("R8");
    err_on = 0;
    reg_read(1'b1, r); chk(r == 32'h1, "R8", "descriptor error bit", r, 32'h1);

    // restart keeps the sticky bit (R11)
    set_desc(32'h340, 32'h780, 16, 0, 1'b1);
    push_frame(32'hE000, 2);
    run_chain(32'h340, "R11", st);
    wait_idle("R11");
    reg_read(1'b1, r); chk(r == 32'h1, "R11", "error bit survives restart", r, 32'h1);
    reg_write(1'b1, 32'h0);
    reg_read(1'b1, r); chk(r == 32'h1, "R11", "write of 0 keeps bit", r, 32'h1);
    reg_write(1'b1, 32'h1);
    reg_read(1'b1, r); chk(r == 32'h0, "R11", "write of 1 clears bit", r, 0);

    // data write error (R9)
    set_desc(32'h380, 32'h800, 16, 0, 1'b1);
    push_frame(32'hF000, 3);
    err_on = 1; err_we = 1; err_addr = 32'h804;
    run_chain(32'h380, "R9", st);
    wait_idle("R9");
    err_on = 0;
    reg_read(1'b1, r); chk(r == 32'h2, "R9", "data error bit", r, 32'h2);
    chk(fq_data.size() == 1, "R9", "no pop after write error", 32'(fq_data.size()), 1);
    fq_data.delete(); fq_last.delete();

    finish_run();
  end
endmodule